// File: doc/BRIEF.md
# Predicate First/Next Active Element Finder

This block performs two walks over a predicate register held as a row of 64-bit words. In "first" mode it takes a governing predicate G and a current predicate D and sets, in D, the lowest set bit of G, leaving every other bit of D as it was. In "next" mode it finds the last active element of D and then returns a one-hot predicate that marks the next active element of G after it. Either way it also reports condition flags that compare the result with the active bits of G. An element of size code k (0 to 3) spans 2^k predicate bits, and only its lowest bit counts as active.

A single-cycle start strobe loads both predicates, the element-size code and the mode. The block then works through one word per cycle. "First" needs one forward pass. "Next" needs a backward scan of D, a forward scan of G and a forward write pass. A one-cycle done pulse marks the cycle from which the result and the flags are valid. They stay valid until the next accepted start.

Top module: `pred_walk`

## Requirements
- R1: In first mode with G non-zero, the result equals D with the lowest set bit of G also set; all other bits of D are unchanged, and the element-size input has no effect.
- R2: In first mode with G all zero, the result equals D.
- R3: In next mode, an element of size code k is active at bit positions that are multiples of 2^k (word masks 64'hFFFF_FFFF_FFFF_FFFF, 64'h5555_5555_5555_5555, 64'h1111_1111_1111_1111, 64'h0101_0101_0101_0101 for k = 0..3). The last active position of D is its highest set bit at an active position. The search starts 2^k bits above that position.
- R4: In next mode, when D has no set bit at an active position, the search starts at bit 0.
- R5: In next mode, the result has exactly one set bit, at the lowest set bit of G at an active position at or above the search start. It is all zeros when there is no such bit, including when the start lies at or past the predicate width.
- R6: The flags are built from the result and the effective G. N is the result bit at the lowest set bit of G. Z is 1 when no result bit is set where G is set. C is the inverse of the result bit at the highest set bit of G. V is always 0. The effective G is G restricted to active positions in next mode and G as given in first mode.
- R7: When the effective G has no set bit, the flags are N=0, Z=1, C=1.
- R8: done is a single-cycle pulse. Counting from the clock edge that accepts start, it rises WORDS edges later in first mode and 3*WORDS edges later in next mode, where WORDS = PRED_BITS/64. The result and the flags are valid from that cycle on and stay valid until the next accepted start.
- R9: busy is high while a walk is in progress. A start strobe that arrives while busy is high is ignored and leaves the running walk unchanged.
- R10: After reset the result is all zeros, the flags are N=0, Z=1, C=1, V=0, and busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, accepted only when idle |
| opNext | input | 1 | Mode select: 0 = first, 1 = next |
| eltSize | input | 2 | Element-size code k (used in next mode) |
| govPred | input | PRED_BITS | Governing predicate G |
| curPred | input | PRED_BITS | Current predicate D |
| resPred | output | PRED_BITS | Resulting predicate |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagC | output | 1 | Carry flag |
| flagV | output | 1 | Overflow flag (always 0) |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The collision that matters is a new start strobe arriving in the same cycle as a step of a running walk. Because the walk is still busy, that strobe must not reload the predicates, the mode or the element size. The bench provokes it by pulsing start one cycle into a walk with the opposite mode and complemented operands. It then checks that the result, the flags and the done latency all match the original request. Back-to-back requests issued right after done confirm that the start of the next walk does not disturb the finished one.

// File: rtl/predwalk_pkg.sv
package predwalk_pkg;

  localparam int WORD_BITS = 64;

  // strobes from the sequencer to the word datapath
  typedef struct packed {
    logic       load;
    logic       stepFirst;
    logic       stepBack;
    logic       stepFwd;
    logic       stepWrite;
    logic [1:0] idx;
  } walkStrobe_t;

  // active-bit pattern of one word for an element-size code
  function automatic logic [63:0] laneMask(input logic [1:0] esz);
    case (esz)
      2'd0:    laneMask = 64'hFFFF_FFFF_FFFF_FFFF;
      2'd1:    laneMask = 64'h5555_5555_5555_5555;
      2'd2:    laneMask = 64'h1111_1111_1111_1111;
      default: laneMask = 64'h0101_0101_0101_0101;
    endcase
  endfunction

  function automatic logic [5:0] lowestSet(input logic [63:0] w);
    lowestSet = '0;
    for (int b = 63; b >= 0; b--) if (w[b]) lowestSet = 6'(b);
  endfunction

  function automatic logic [5:0] highestSet(input logic [63:0] w);
    highestSet = '0;
    for (int b = 0; b < 64; b++) if (w[b]) highestSet = 6'(b);
  endfunction

endpackage

// File: rtl/predwalk_ctrl.sv
module predwalk_ctrl
  import predwalk_pkg::*;
#(
  parameter int WORDS = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        opNext,
  output walkStrobe_t stb,
  output logic        busy,
  output logic        done,
  output logic        nextMode
);

  localparam int IDXW = (WORDS > 1) ? $clog2(WORDS) : 1;

  typedef enum logic [2:0] {S_IDLE, S_FIRST, S_BACK, S_FWD, S_WRITE} walkState_t;

  walkState_t state, stateNxt;
  logic [IDXW-1:0] cnt;
  logic lastWord;
  logic opReg;

  assign lastWord = (cnt == IDXW'(WORDS - 1));
  assign busy     = (state != S_IDLE);
  assign nextMode = opReg;

  always_comb begin
    stb           = '0;
    stb.load      = (state == S_IDLE) && start;
    stb.stepFirst = (state == S_FIRST);
    stb.stepBack  = (state == S_BACK);
    stb.stepFwd   = (state == S_FWD);
    stb.stepWrite = (state == S_WRITE);
    stb.idx       = (state == S_BACK) ? 2'(WORDS - 1 - int'(cnt)) : 2'(cnt);
  end

  always_comb begin
    stateNxt = state;
    case (state)
      S_IDLE:  if (start) stateNxt = opNext ? S_BACK : S_FIRST;
      S_FIRST: if (lastWord) stateNxt = S_IDLE;
      S_BACK:  if (lastWord) stateNxt = S_FWD;
      S_FWD:   if (lastWord) stateNxt = S_WRITE;
      S_WRITE: if (lastWord) stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
      opReg <= 1'b0;
    end else begin
      state <= stateNxt;
      if (state == S_IDLE || lastWord) cnt <= '0;
      else cnt <= cnt + 1'b1;
      done <= ((state == S_FIRST) || (state == S_WRITE)) && lastWord;
      if (stb.load) opReg <= opNext;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> $stable(opReg));  // R9

endmodule

// File: rtl/predwalk_dp.sv
module predwalk_dp
  import predwalk_pkg::*;
#(
  parameter int PRED_BITS = 128
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  walkStrobe_t          stb,
  input  logic [PRED_BITS-1:0] govPred,
  input  logic [PRED_BITS-1:0] curPred,
  input  logic [1:0]           eltSize,
  output logic [PRED_BITS-1:0] resPred,
  output logic                 flagN,
  output logic                 flagZ,
  output logic                 flagC
);

  localparam int WORDS = PRED_BITS / WORD_BITS;
  localparam int POSW  = $clog2(PRED_BITS) + 1;

  logic [63:0] gWord [WORDS];
  logic [63:0] dWord [WORDS];
  logic [1:0]  eszR;
  logic        lastHit, nextHit, seen;
  logic [POSW-1:0] lastPos, nextPos, startPos, eltBits;

  logic [63:0] gSel, dSel, mask, geMask, newD, gFlag, dAct, gCand;
  logic [5:0]  hiD, loG, loFirst, gLo, gHi;
  logic        nN, nZ, nC, nSeen;

  always_comb begin
    gSel = '0;
    dSel = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (w == int'(stb.idx)) begin
        gSel = gWord[w];
        dSel = dWord[w];
      end
    end
  end

  assign mask     = laneMask(eszR);
  assign eltBits  = POSW'(1) << eszR;
  assign startPos = lastHit ? (lastPos + eltBits) : '0;

  always_comb begin
    for (int b = 0; b < 64; b++)
      geMask[b] = (int'(stb.idx) * 64 + b) >= int'(startPos);
  end

  assign dAct    = dSel & mask;
  assign gCand   = gSel & mask & geMask;
  assign hiD     = highestSet(dAct);
  assign loG     = lowestSet(gCand);
  assign loFirst = lowestSet(gSel);

  // new word for the writing passes and the G view used for flags
  always_comb begin
    if (stb.stepFirst) begin
      gFlag = gSel;
      newD  = ((gSel != '0) && !seen) ? (dSel | (64'd1 << loFirst)) : dSel;
    end else begin
      gFlag = gSel & mask;
      newD  = (nextHit && (int'(nextPos >> 6) == int'(stb.idx)))
              ? (64'd1 << nextPos[5:0]) : '0;
    end
  end

  assign gLo = lowestSet(gFlag);
  assign gHi = highestSet(gFlag);

  always_comb begin
    nN    = flagN;
    nZ    = flagZ;
    nC    = flagC;
    nSeen = seen;
    if (gFlag != '0) begin
      if (!seen) begin
        nN    = newD[gLo];
        nSeen = 1'b1;
      end
      if ((newD & gFlag) != '0) nZ = 1'b0;
      nC = !newD[gHi];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < WORDS; w++) begin
        gWord[w] <= '0;
        dWord[w] <= '0;
      end
      eszR    <= '0;
      lastHit <= 1'b0;
      nextHit <= 1'b0;
      lastPos <= '0;
      nextPos <= '0;
      seen    <= 1'b0;
      flagN   <= 1'b0;
      flagZ   <= 1'b1;
      flagC   <= 1'b1;
    end else if (stb.load) begin
      for (int w = 0; w < WORDS; w++) begin
        gWord[w] <= govPred[w*WORD_BITS +: WORD_BITS];
        dWord[w] <= curPred[w*WORD_BITS +: WORD_BITS];
      end
      eszR    <= eltSize;
      lastHit <= 1'b0;
      nextHit <= 1'b0;
      lastPos <= '0;
      nextPos <= '0;
      seen    <= 1'b0;
      flagN   <= 1'b0;
      flagZ   <= 1'b1;
      flagC   <= 1'b1;
    end else begin
      if (stb.stepBack && !lastHit && (dAct != '0)) begin
        lastHit <= 1'b1;
        lastPos <= POSW'(int'(stb.idx) * 64 + int'(hiD));
      end
      if (stb.stepFwd && !nextHit && (gCand != '0)) begin
        nextHit <= 1'b1;
        nextPos <= POSW'(int'(stb.idx) * 64 + int'(loG));
      end
      if (stb.stepFirst || stb.stepWrite) begin
        for (int w = 0; w < WORDS; w++)
          if (w == int'(stb.idx)) dWord[w] <= newD;
        flagN <= nN;
        flagZ <= nZ;
        flagC <= nC;
        seen  <= nSeen;
      end
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : gOut
    assign resPred[w*WORD_BITS +: WORD_BITS] = dWord[w];
  end

  AST_Z_IMPLIES_C: assert property (@(posedge clk) disable iff (!rstN)
    flagZ |-> flagC);  // R6
  AST_N_EXCLUDES_Z: assert property (@(posedge clk) disable iff (!rstN)
    flagN |-> !flagZ);  // R6
  AST_LOAD_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> (!flagN && flagZ && flagC));  // R7

endmodule

// File: rtl/pred_walk.sv
module pred_walk
  import predwalk_pkg::*;
#(
  parameter int PRED_BITS = 128
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic                 opNext,
  input  logic [1:0]           eltSize,
  input  logic [PRED_BITS-1:0] govPred,
  input  logic [PRED_BITS-1:0] curPred,
  output logic [PRED_BITS-1:0] resPred,
  output logic                 flagN,
  output logic                 flagZ,
  output logic                 flagC,
  output logic                 flagV,
  output logic                 busy,
  output logic                 done
);

  localparam int WORDS = PRED_BITS / WORD_BITS;

  walkStrobe_t stb;
  logic nextMode;

  predwalk_ctrl #(.WORDS(WORDS)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .opNext(opNext),
    .stb(stb), .busy(busy), .done(done), .nextMode(nextMode)
  );

  predwalk_dp #(.PRED_BITS(PRED_BITS)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .govPred(govPred), .curPred(curPred),
    .eltSize(eltSize), .resPred(resPred),
    .flagN(flagN), .flagZ(flagZ), .flagC(flagC)
  );

  assign flagV = 1'b0;

  AST_NEXT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    (done && nextMode) |-> $onehot0(resPred));  // R5

endmodule

// File: tb/tb_pred_walk.sv
module tb_pred_walk;

  localparam int PB      = 128;
  localparam int WORDS   = PB / 64;
  localparam int CLK_PER = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic opNext = 1'b0;
  logic [1:0] eltSize = '0;
  logic [PB-1:0] govPred = '0, curPred = '0;
  logic [PB-1:0] resPred;
  logic flagN, flagZ, flagC, flagV, busy, done;

  pred_walk #(.PRED_BITS(PB)) dut (
    .clk(clk), .rstN(rstN), .start(start), .opNext(opNext), .eltSize(eltSize),
    .govPred(govPred), .curPred(curPred), .resPred(resPred),
    .flagN(flagN), .flagZ(flagZ), .flagC(flagC), .flagV(flagV),
    .busy(busy), .done(done)
  );

  always #(CLK_PER/2) clk = ~clk;

  typedef struct {
    logic [PB-1:0] expRes;
    logic [2:0]    expFlags;
    int            acceptCyc;
    int            latency;
    string         tag;
  } sbItem_t;

  sbItem_t sbQ[$];
  int nChecks = 0;
  int nErrs = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic checkVal(input string tag, input string what,
                          input logic [PB-1:0] act, input logic [PB-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrs++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [PB-1:0] activeMask(input logic [1:0] esz);
    logic [PB-1:0] m;
    for (int b = 0; b < PB; b++) m[b] = ((b % (1 << esz)) == 0);
    return m;
  endfunction

  // {N,Z,C}
  function automatic logic [2:0] modelFlags(input logic [PB-1:0] r, input logic [PB-1:0] g);
    int lo, hi;
    if (g == '0) return 3'b011;
    lo = -1; hi = -1;
    for (int b = 0; b < PB; b++) if (g[b]) begin
      if (lo < 0) lo = b;
      hi = b;
    end
    return {r[lo], ((r & g) == '0), !r[hi]};
  endfunction

  function automatic logic [PB-1:0] modelFirst(input logic [PB-1:0] g, input logic [PB-1:0] d);
    return (g == '0) ? d : (d | (g & (~g + 1'b1)));
  endfunction

  function automatic logic [PB-1:0] modelNext(input logic [PB-1:0] g, input logic [PB-1:0] d,
                                              input logic [1:0] esz);
    logic [PB-1:0] m, dm, gm, r;
    int st;
    m = activeMask(esz); dm = d & m; gm = g & m; r = '0;
    st = 0;
    for (int b = 0; b < PB; b++) if (dm[b]) st = b + (1 << esz);
    for (int b = PB - 1; b >= 0; b--) if (b >= st && gm[b]) r = '0 | (1 << 0) << b;
    return r;
  endfunction

  always @(negedge clk) begin
    if (rstN && done) begin
      if (sbQ.size() == 0) begin
        nChecks++; nErrs++;
        $display("FAIL R8 unexpected done: actual 1 expected 0");
      end else begin
        sbItem_t it;
        it = sbQ.pop_front();
        checkVal(it.tag, "result", resPred, it.expRes);
        checkVal({it.tag, " R6"}, "flags NZC", PB'({flagN, flagZ, flagC}), PB'(it.expFlags));
        checkVal("R6", "flagV", PB'(flagV), '0);
        checkVal("R8", "done latency", PB'(cyc), PB'(it.acceptCyc + it.latency));
      end
    end
  end

  task automatic runOp(input logic op, input logic [1:0] esz, input logic [PB-1:0] g,
                       input logic [PB-1:0] d, input string tag, input bit intrude);
    sbItem_t it;
    @(negedge clk);
    if (op) begin
      it.expRes = modelNext(g, d, esz);
      it.expFlags = modelFlags(it.expRes, g & activeMask(esz));
      it.latency = 3 * WORDS;
    end else begin
      it.expRes = modelFirst(g, d);
      it.expFlags = modelFlags(it.expRes, g);
      it.latency = WORDS;
    end
    it.acceptCyc = cyc + 1;
    it.tag = tag;
    sbQ.push_back(it);
    start = 1'b1; opNext = op; eltSize = esz; govPred = g; curPred = d;
    @(negedge clk);
    start = 1'b0;
    checkVal("R9", "busy during walk", PB'(busy), PB'(1));
    if (intrude) begin
      start = 1'b1; opNext = !op; eltSize = esz + 2'd1; govPred = ~g; curPred = ~d;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    checkVal("R8", "done single pulse", PB'(done), '0);
    checkVal("R8", "result held", resPred, it.expRes);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErrs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkVal("R10", "reset result", resPred, '0);
    checkVal("R10", "reset flags NZCV", PB'({flagN, flagZ, flagC, flagV}), PB'(4'b0110));
    checkVal("R10", "reset busy/done", PB'({busy, done}), '0);
    rstN = 1'b1;
    @(negedge clk);

    // first mode
    runOp(1'b0, 2'd0, '0, 128'h0000_00F0_0000_0000_8000_0000_0000_0001, "R2 zero G", 1'b0);
    runOp(1'b0, 2'd3, 128'h0000_0000_0000_0440_0000_0000_0000_0000,
          128'h8000_0000_0000_0000_0000_0000_0000_0002, "R1 lowest in upper word", 1'b0);
    runOp(1'b0, 2'd1, 128'h0000_0000_0000_0000_0000_0000_0000_0108,
          128'h0000_0000_0000_0000_0000_0000_0000_0008, "R1 bit already set", 1'b0);
    // next mode
    runOp(1'b1, 2'd0, (128'd1 << 3) | (128'd1 << 6) | (128'd1 << 100), 128'd1 << 5,
          "R5 basic next", 1'b0);
    runOp(1'b1, 2'd0, (128'd1 << 9) | (128'd1 << 70), '0, "R4 empty D", 1'b0);
    runOp(1'b1, 2'd2, (128'd1 << 9) | (128'd1 << 12), (128'd1 << 4) | (128'd1 << 7),
          "R3 unaligned bits skipped", 1'b0);
    runOp(1'b1, 2'd3, {PB{1'b1}}, 128'd1 << 120, "R5 start past end", 1'b0);
    runOp(1'b1, 2'd0, (128'd1 << 2), 128'd1 << 40, "R5 no G above", 1'b0);
    runOp(1'b1, 2'd0, (128'd1 << 64), 128'd1 << 60, "R5 crosses word", 1'b0);
    runOp(1'b1, 2'd1, {PB{1'b1}}, 128'd1 << 127, "R3 odd top bit ignored", 1'b0);
    runOp(1'b1, 2'd1, 128'hAAAA_AAAA_AAAA_AAAA_AAAA_AAAA_AAAA_AAAA, '0, "R7 no active G", 1'b0);
    // start while busy
    runOp(1'b0, 2'd0, 128'd1 << 77, 128'd1 << 3, "R9 start ignored (first)", 1'b1);
    runOp(1'b1, 2'd2, (128'd1 << 20) | (128'd1 << 96), 128'd1 << 16, "R9 start ignored (next)", 1'b1);
    // mixed patterns
    for (int i = 0; i < 24; i++) begin
      logic [PB-1:0] g, d;
      g = {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom}
          & {$urandom, $urandom, $urandom, $urandom};
      d = {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom}
          & {$urandom, $urandom, $urandom, $urandom};
      if (i % 5 == 0) d = '0;
      runOp(1'($urandom), 2'($urandom), g, d, "R5 R1 mixed", (i % 3) == 0);
    end

    repeat (2) @(negedge clk);
    checkVal("R8", "scoreboard drained", PB'(sbQ.size()), '0);
    $display("  Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
    $finish;
  end

endmodule